// File: doc/BRIEF.md
# Rectangle Fill Command Engine

This block carries out one solid-fill command for a 1280 by 1024 pixel framebuffer, the kind a text console sends to blank whole rows or columns of characters. It takes the command packet in one cycle as a set of 32-bit words: an opcode, a line width, an attribute, and two vertices, each holding an x and a y field. It works out the covered rectangle from these words and picks the fill value. It then emits one framebuffer write per clock, in row-major order, on a synchronous write port: the framebuffer stores `fb_data` at (`fb_x`, `fb_y`) on each rising edge where `fb_we` is high.

Each vertex is first reduced by the line width. The x coordinate comes from bits 29:19 and the y coordinate from bits 12:3. The line width then adds extra rows below the second vertex, after rounding it to a quarter. A second per-command input selects the pixel format. In 24-bit RGB the attribute is mapped to black, mid grey or white. In 8-bit indexed mode the attribute's low byte is written as it is. The block also keeps a dirty rectangle that grows to cover everything written since reset, so a display refresh can be limited to that area.

Top module: `rect_fill_engine`

## Requirements
- R1: A command is taken only on a cycle with `cmd_valid` high, `busy` low and `cmd_opcode` equal to 32'h0000_0411. Any other opcode, or any command offered while `busy` is high, causes no write, no `done` pulse and no change to the dirty rectangle.
- R2: With a = vertex word − `cmd_lw` (32-bit wrap), x = a[29:19] and y = a[12:3]. Vertex one gives the left column x0 and the top row y0. Vertex two gives the raw right bound x1 and the raw bottom y1.
- R3: Rows y0 up to, but not including, y1 + ((`cmd_lw` + 1) mod 2^32 >> 2) are filled. That end bound is capped at 1024.
- R4: Columns x0 up to, but not including, xe are filled. xe equals x1, or 1280 when x1 − x0 is greater than 1280.
- R5: Writes come one per cycle, column by column within a row and row by row downward. The first write is in the cycle after the command is taken, and `fb_x` goes up by one between neighbouring writes of a row.
- R6: With `cmd_rgb` high, `fb_data` is 24'h000000 when attribute bits 23:16 are 0, 24'hC0C0C0 when they are 7, and 24'hFFFFFF for any other value. The value is the same for every write of the command.
- R7: With `cmd_rgb` low, `fb_data[7:0]` is the attribute's bits 7:0 and `fb_data[23:8]` is zero.
- R8: After reset the dirty rectangle reads x_lo=2047, x_hi=0, y_lo=1023, y_hi=0. A command that writes pixels widens x_lo/x_hi to include x0 and xe (xe exclusive), and widens y_lo/y_hi to include every row written.
- R9: A taken command with xe ≤ x0, or with a row end ≤ y0, makes no write and leaves `busy` low. It gives a `done` pulse in the next cycle and leaves the dirty rectangle unchanged.
- R10: `busy` is high from the cycle after a non-empty command is taken through its last write. `done` is a one-cycle pulse in the cycle that follows the last write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command packet present this cycle |
| cmd_opcode | input | 32 | Packet opcode word |
| cmd_lw | input | 32 | Line-width word |
| cmd_attr | input | 32 | Attribute word |
| cmd_v1 | input | 32 | First (top-left) vertex word |
| cmd_v2 | input | 32 | Second (bottom-right) vertex word |
| cmd_rgb | input | 1 | 1: 24-bit RGB pixels, 0: 8-bit indexed |
| busy | output | 1 | Fill in progress |
| done | output | 1 | One-cycle completion pulse |
| fb_we | output | 1 | Framebuffer write strobe |
| fb_x | output | 11 | Write column |
| fb_y | output | 10 | Write row |
| fb_data | output | 24 | Write pixel value |
| dirty_x_lo | output | 11 | Dirty rectangle left column |
| dirty_x_hi | output | 11 | Dirty rectangle right bound (exclusive) |
| dirty_y_lo | output | 10 | Dirty rectangle top row |
| dirty_y_hi | output | 10 | Dirty rectangle bottom row (inclusive) |

## Verification
The assertions check these properties on every cycle:
- every write lies inside the column span and row bound of its command;
- neighbouring writes in a row step x by one;
- the pixel value is held for the whole command;
- `done` never overlaps `busy`;
- a wrong opcode never starts work;
- the dirty rows always cover the row just written.

Only the bench scenarios can show that the decoded bounds themselves are right. That covers the borrow from the line-width subtraction, the 1280-column cap, the 1024-row cap, the grey mapping and the exact count and order of writes. The same holds for a command offered while busy being dropped, and for empty rectangles finishing at once.

// File: rtl/rect_fill_pkg.sv
package rect_fill_pkg;

  // Packet layout and fill constants
  localparam logic [31:0] FILL_OPCODE = 32'h0000_0411;
  localparam int unsigned X_LSB       = 19;
  localparam int unsigned Y_LSB       = 3;
  localparam logic [7:0]  SHADE_DARK  = 8'd0;
  localparam logic [7:0]  SHADE_MID   = 8'd7;
  localparam logic [7:0]  LEVEL_MID   = 8'd192;
  localparam logic [7:0]  LEVEL_FULL  = 8'd255;

  typedef enum logic [0:0] {
    SC_IDLE = 1'b0,
    SC_RUN  = 1'b1
  } scan_state_t;

endpackage

// File: rtl/rf_reset_sync.sv
module rf_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/rf_decode.sv
module rf_decode
  import rect_fill_pkg::*;
#(
  parameter int unsigned FB_W = 1280,
  parameter int unsigned FB_H = 1024,
  parameter int unsigned XW   = 11,
  parameter int unsigned YW   = 10,
  parameter int unsigned WW   = 32
) (
  input  logic [WW-1:0] lw_i,
  input  logic [WW-1:0] v1_i,
  input  logic [WW-1:0] v2_i,
  output logic [XW-1:0] x_lo_o,
  output logic [XW-1:0] x_hi_o,
  output logic [YW-1:0] y_lo_o,
  output logic [YW:0]   y_end_o,
  output logic          empty_o
);

  localparam int unsigned SUMW = WW + 1;

  logic [WW-1:0]   adj1;
  logic [WW-1:0]   adj2;
  logic [XW-1:0]   x_raw;
  logic [YW-1:0]   y_raw;
  logic [XW:0]     span;
  logic [WW-1:0]   lw_inc;
  logic [WW-1:0]   lw_rows;
  logic [SUMW-1:0] row_sum;

  always_comb begin
    adj1    = v1_i - lw_i;
    adj2    = v2_i - lw_i;
    x_lo_o  = adj1[X_LSB +: XW];
    y_lo_o  = adj1[Y_LSB +: YW];
    x_raw   = adj2[X_LSB +: XW];
    y_raw   = adj2[Y_LSB +: YW];

    // horizontal cap on over-wide spans
    span = {1'b0, x_raw} - {1'b0, x_lo_o};
    if ((x_raw > x_lo_o) && (span > (XW+1)'(FB_W))) begin
      x_hi_o = XW'(FB_W);
    end else begin
      x_hi_o = x_raw;
    end

    // line width becomes extra rows with a rounding shift
    lw_inc  = lw_i + WW'(1);
    lw_rows = lw_inc >> 2;
    row_sum = SUMW'(y_raw) + SUMW'(lw_rows);
    if (row_sum > SUMW'(FB_H)) begin
      y_end_o = (YW+1)'(FB_H);
    end else begin
      y_end_o = row_sum[YW:0];
    end

    empty_o = (x_hi_o <= x_lo_o) || (y_end_o <= {1'b0, y_lo_o});
  end

endmodule

// File: rtl/rf_colour.sv
module rf_colour
  import rect_fill_pkg::*;
#(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned WW    = 32
) (
  input  logic [WW-1:0]    attr_i,
  input  logic             rgb_i,
  output logic [PIX_W-1:0] pix_o
);

  localparam int unsigned CH    = PIX_W / 3;
  localparam int unsigned SEL_L = 2 * CH;

  logic [CH-1:0] shade_code;
  logic [CH-1:0] level;

  always_comb begin
    shade_code = attr_i[SEL_L +: CH];
    if (shade_code == SHADE_DARK) begin
      level = '0;
    end else if (shade_code == SHADE_MID) begin
      level = LEVEL_MID;
    end else begin
      level = LEVEL_FULL;
    end

    if (rgb_i) begin
      pix_o = {3{level}};
    end else begin
      pix_o = {{(PIX_W-CH){1'b0}}, attr_i[CH-1:0]};
    end
  end

endmodule

// File: rtl/rf_scan.sv
module rf_scan
  import rect_fill_pkg::*;
#(
  parameter int unsigned XW    = 11,
  parameter int unsigned YW    = 10,
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             empty_i,
  input  logic [XW-1:0]    x_lo_i,
  input  logic [XW-1:0]    x_hi_i,
  input  logic [YW-1:0]    y_lo_i,
  input  logic [YW:0]      y_end_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             we_o,
  output logic [XW-1:0]    x_o,
  output logic [YW-1:0]    y_o,
  output logic [PIX_W-1:0] data_o
);

  scan_state_t      state_q, state_d;
  logic [XW-1:0]    cx_q, cx_d;
  logic [YW-1:0]    cy_q, cy_d;
  logic [XW-1:0]    xlo_q;
  logic [XW-1:0]    xhi_q;
  logic [YW:0]      yend_q;
  logic [PIX_W-1:0] pix_q;
  logic             done_q, done_d;
  logic             job_en;
  logic             row_end;
  logic             last_row;

  always_comb begin
    row_end  = ({1'b0, cx_q} + (XW+1)'(1)) == {1'b0, xhi_q};
    last_row = ({1'b0, cy_q} + (YW+1)'(1)) == yend_q;
    job_en   = (state_q == SC_IDLE) && start_i;

    state_d = state_q;
    cx_d    = cx_q;
    cy_d    = cy_q;
    done_d  = 1'b0;

    unique case (state_q)
      SC_IDLE: begin
        if (start_i) begin
          if (empty_i) begin
            done_d = 1'b1;
          end else begin
            state_d = SC_RUN;
            cx_d    = x_lo_i;
            cy_d    = y_lo_i;
          end
        end
      end
      SC_RUN: begin
        if (row_end) begin
          cx_d = xlo_q;
          if (last_row) begin
            state_d = SC_IDLE;
            done_d  = 1'b1;
          end else begin
            cy_d = cy_q + YW'(1);
          end
        end else begin
          cx_d = cx_q + XW'(1);
        end
      end
      default: state_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      cx_q    <= '0;
      cy_q    <= '0;
      done_q  <= 1'b0;
      xlo_q   <= '0;
      xhi_q   <= '0;
      yend_q  <= '0;
      pix_q   <= '0;
    end else begin
      state_q <= state_d;
      cx_q    <= cx_d;
      cy_q    <= cy_d;
      done_q  <= done_d;
      if (job_en) begin
        xlo_q  <= x_lo_i;
        xhi_q  <= x_hi_i;
        yend_q <= y_end_i;
        pix_q  <= pix_i;
      end
    end
  end

  assign busy_o = (state_q == SC_RUN);
  assign we_o   = (state_q == SC_RUN);
  assign done_o = done_q;
  assign x_o    = cx_q;
  assign y_o    = cy_q;
  assign data_o = pix_q;

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R10

  AST_COL_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> (x_o >= xlo_q) && (x_o < xhi_q)); // R4

  AST_ROW_IN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> ({1'b0, y_o} < yend_q)); // R3

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    we_o && $past(we_o) && (y_o == $past(y_o)) |-> x_o == $past(x_o) + XW'(1)); // R5

  AST_PIX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    we_o && $past(we_o) |-> $stable(data_o)); // R6

endmodule

// File: rtl/rf_dirty.sv
module rf_dirty #(
  parameter int unsigned XW = 11,
  parameter int unsigned YW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          span_load_i,
  input  logic [XW-1:0] span_lo_i,
  input  logic [XW-1:0] span_hi_i,
  input  logic          px_we_i,
  input  logic [YW-1:0] px_y_i,
  output logic [XW-1:0] x_lo_o,
  output logic [XW-1:0] x_hi_o,
  output logic [YW-1:0] y_lo_o,
  output logic [YW-1:0] y_hi_o
);

  logic [XW-1:0] xl_q, xl_d, xh_q, xh_d;
  logic [YW-1:0] yl_q, yl_d, yh_q, yh_d;

  always_comb begin
    xl_d = xl_q;
    xh_d = xh_q;
    yl_d = yl_q;
    yh_d = yh_q;
    if (span_load_i) begin
      if (span_lo_i < xl_q) xl_d = span_lo_i;
      if (span_hi_i > xh_q) xh_d = span_hi_i;
    end
    if (px_we_i) begin
      if (px_y_i < yl_q) yl_d = px_y_i;
      if (px_y_i > yh_q) yh_d = px_y_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_q <= '1;
      xh_q <= '0;
      yl_q <= '1;
      yh_q <= '0;
    end else begin
      xl_q <= xl_d;
      xh_q <= xh_d;
      yl_q <= yl_d;
      yh_q <= yh_d;
    end
  end

  assign x_lo_o = xl_q;
  assign x_hi_o = xh_q;
  assign y_lo_o = yl_q;
  assign y_hi_o = yh_q;

  AST_DIRTY_HAS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    px_we_i |=> (y_lo_o <= $past(px_y_i)) && (y_hi_o >= $past(px_y_i))); // R8

  AST_DIRTY_HAS_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    span_load_i |=> (x_lo_o <= $past(span_lo_i)) && (x_hi_o >= $past(span_hi_i))); // R8

endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
  import rect_fill_pkg::*;
#(
  parameter int unsigned FB_W       = 1280,
  parameter int unsigned FB_H       = 1024,
  parameter int unsigned XW         = 11,
  parameter int unsigned YW         = 10,
  parameter int unsigned PIX_W      = 24,
  parameter int unsigned WW         = 32,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [WW-1:0]    cmd_opcode,
  input  logic [WW-1:0]    cmd_lw,
  input  logic [WW-1:0]    cmd_attr,
  input  logic [WW-1:0]    cmd_v1,
  input  logic [WW-1:0]    cmd_v2,
  input  logic             cmd_rgb,
  output logic             busy,
  output logic             done,
  output logic             fb_we,
  output logic [XW-1:0]    fb_x,
  output logic [YW-1:0]    fb_y,
  output logic [PIX_W-1:0] fb_data,
  output logic [XW-1:0]    dirty_x_lo,
  output logic [XW-1:0]    dirty_x_hi,
  output logic [YW-1:0]    dirty_y_lo,
  output logic [YW-1:0]    dirty_y_hi
);

  logic             rst_n_int;
  logic             take;
  logic [XW-1:0]    dec_x_lo;
  logic [XW-1:0]    dec_x_hi;
  logic [YW-1:0]    dec_y_lo;
  logic [YW:0]      dec_y_end;
  logic             dec_empty;
  logic [PIX_W-1:0] dec_pix;

  rf_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  assign take = cmd_valid && !busy && (cmd_opcode == FILL_OPCODE);

  rf_decode #(.FB_W(FB_W), .FB_H(FB_H), .XW(XW), .YW(YW), .WW(WW)) u_dec (
    .lw_i    (cmd_lw),
    .v1_i    (cmd_v1),
    .v2_i    (cmd_v2),
    .x_lo_o  (dec_x_lo),
    .x_hi_o  (dec_x_hi),
    .y_lo_o  (dec_y_lo),
    .y_end_o (dec_y_end),
    .empty_o (dec_empty)
  );

  rf_colour #(.PIX_W(PIX_W), .WW(WW)) u_col (
    .attr_i (cmd_attr),
    .rgb_i  (cmd_rgb),
    .pix_o  (dec_pix)
  );

  rf_scan #(.XW(XW), .YW(YW), .PIX_W(PIX_W)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start_i (take),
    .empty_i (dec_empty),
    .x_lo_i  (dec_x_lo),
    .x_hi_i  (dec_x_hi),
    .y_lo_i  (dec_y_lo),
    .y_end_i (dec_y_end),
    .pix_i   (dec_pix),
    .busy_o  (busy),
    .done_o  (done),
    .we_o    (fb_we),
    .x_o     (fb_x),
    .y_o     (fb_y),
    .data_o  (fb_data)
  );

  rf_dirty #(.XW(XW), .YW(YW)) u_dirty (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .span_load_i (take && !dec_empty),
    .span_lo_i   (dec_x_lo),
    .span_hi_i   (dec_x_hi),
    .px_we_i     (fb_we),
    .px_y_i      (fb_y),
    .x_lo_o      (dirty_x_lo),
    .x_hi_o      (dirty_x_hi),
    .y_lo_o      (dirty_y_lo),
    .y_hi_o      (dirty_y_hi)
  );

  AST_BAD_OPCODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    cmd_valid && !busy && (cmd_opcode != FILL_OPCODE) |=> !busy && !done); // R1

  AST_EMPTY_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n_int)
    take && dec_empty |=> done && !fb_we); // R9

endmodule

// File: tb/test_rect_fill_engine.sv
module test_rect_fill_engine;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [31:0] cmd_opcode, cmd_lw, cmd_attr, cmd_v1, cmd_v2;
  logic        cmd_rgb;
  logic        busy, done, fb_we;
  logic [10:0] fb_x;
  logic [9:0]  fb_y;
  logic [23:0] fb_data;
  logic [10:0] dirty_x_lo, dirty_x_hi;
  logic [9:0]  dirty_y_lo, dirty_y_hi;

  int checks;
  int fails;
  bit finished;

  // bench-side dirty model
  int m_xl, m_xh, m_yl, m_yh;

  rect_fill_engine i_rect_fill_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
    .cmd_lw(cmd_lw), .cmd_attr(cmd_attr), .cmd_v1(cmd_v1), .cmd_v2(cmd_v2),
    .cmd_rgb(cmd_rgb), .busy(busy), .done(done), .fb_we(fb_we), .fb_x(fb_x),
    .fb_y(fb_y), .fb_data(fb_data), .dirty_x_lo(dirty_x_lo),
    .dirty_x_hi(dirty_x_hi), .dirty_y_lo(dirty_y_lo), .dirty_y_hi(dirty_y_hi)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int col_of(input logic [31:0] v, input logic [31:0] lw);
    logic [31:0] a;
    a = v - lw;
    return int'(a[29:19]);
  endfunction

  function automatic int row_of(input logic [31:0] v, input logic [31:0] lw);
    logic [31:0] a;
    a = v - lw;
    return int'(a[12:3]);
  endfunction

  function automatic int right_of(input logic [31:0] v1, v2, lw);
    int x0, x1;
    x0 = col_of(v1, lw);
    x1 = col_of(v2, lw);
    if (x1 - x0 > 1280) x1 = 1280;
    return x1;
  endfunction

  function automatic longint rowend_of(input logic [31:0] v2, lw);
    logic [31:0] t;
    longint e;
    t = lw + 32'd1;
    e = longint'(row_of(v2, lw)) + longint'(t >> 2);
    if (e > 1024) e = 1024;
    return e;
  endfunction

  function automatic logic [23:0] pix_of(input logic [31:0] attr, input logic rgb);
    if (!rgb) return {16'h0, attr[7:0]};
    if (attr[23:16] == 8'd0) return 24'h000000;
    if (attr[23:16] == 8'd7) return 24'hC0C0C0;
    return 24'hFFFFFF;
  endfunction

  task automatic check_dirty(input string req);
    check(dirty_x_lo == m_xl[10:0] && dirty_x_hi == m_xh[10:0] &&
          dirty_y_lo == m_yl[9:0] && dirty_y_hi == m_yh[9:0], req, "dirty rect",
          {dirty_x_lo, dirty_x_hi, dirty_y_lo, dirty_y_hi},
          {m_xl[10:0], m_xh[10:0], m_yl[9:0], m_yh[9:0]});
  endtask

  // Issue one command; poke=1 offers a second command while busy (must be dropped).
  task automatic run_cmd(input logic [31:0] op, lw, attr, v1, v2,
                         input logic rgb, input bit poke, input string req);
    int x0, xe, y0, ye, ex, ey, nw, bad, guard;
    logic [23:0] pv;
    bit okop, empty, poked;
    okop  = (op == 32'h411);
    x0    = col_of(v1, lw);
    y0    = row_of(v1, lw);
    xe    = right_of(v1, v2, lw);
    ye    = int'(rowend_of(v2, lw));
    pv    = pix_of(attr, rgb);
    empty = (xe <= x0) || (ye <= y0);

    @(negedge clk);
    cmd_valid = 1'b1; cmd_opcode = op; cmd_lw = lw; cmd_attr = attr;
    cmd_v1 = v1; cmd_v2 = v2; cmd_rgb = rgb;
    @(negedge clk);
    cmd_valid = 1'b0;

    if (!okop) begin
      nw = 0;
      for (int k = 0; k < 4; k++) begin
        if (fb_we || busy || done) nw++;
        @(negedge clk);
      end
      check(nw == 0, "R1", "bad opcode activity", nw, 0);
      check_dirty("R1");
      return;
    end

    if (empty) begin
      check(done && !busy && !fb_we, "R9", "empty completes at once",
            {done, busy, fb_we}, 3'b100);
      @(negedge clk);
      check(!done && !fb_we, "R9", "empty pulse ends", {done, fb_we}, 2'b00);
      check_dirty("R9");
      return;
    end

    if (x0 < m_xl) m_xl = x0;
    if (xe > m_xh) m_xh = xe;
    if (y0 < m_yl) m_yl = y0;
    if (ye - 1 > m_yh) m_yh = ye - 1;

    ex = x0; ey = y0; nw = 0; bad = 0; guard = 0; poked = 0;
    while (!done && guard < 20000) begin
      if (poke && !poked) begin
        cmd_valid = 1'b1; cmd_opcode = 32'h411; cmd_lw = 0; cmd_attr = 32'h00FF_0055;
        cmd_v1 = (32'd900 << 19) | (32'd900 << 3); cmd_v2 = (32'd950 << 19) | (32'd950 << 3);
      end
      if (fb_we) begin
        if (bad == 0 && (fb_x != ex[10:0] || fb_y != ey[9:0] || fb_data != pv || !busy)) begin
          bad++;
          $display("FAIL %s pixel %0d: actual x=%0d y=%0d d=%0h expected x=%0d y=%0d d=%0h",
                   req, nw, fb_x, fb_y, fb_data, ex, ey, pv);
        end
        nw++;
        ex++;
        if (ex == xe) begin ex = x0; ey++; end
      end else if (!done) begin
        bad++;
      end
      @(negedge clk);
      if (poke && !poked) begin cmd_valid = 1'b0; poked = 1; end
      guard++;
    end
    checks++;
    if (bad != 0) fails++;
    check(nw == (xe - x0) * (ye - y0), req, "write count", nw, (xe - x0) * (ye - y0));
    check(done && !busy, "R10", "done after last write", {done, busy}, 2'b10);
    @(negedge clk);
    check(!done && !fb_we, "R10", "done is one cycle", {done, fb_we}, 2'b00);
    check_dirty("R8");
  endtask

  function automatic logic [31:0] vpack(input int x, input int y, input int low);
    return (32'(x) << 19) | (32'(y) << 3) | 32'(low);
  endfunction

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    checks = 0; fails = 0; finished = 0;
    m_xl = 2047; m_xh = 0; m_yl = 1023; m_yh = 0;
    cmd_valid = 0; cmd_opcode = 0; cmd_lw = 0; cmd_attr = 0;
    cmd_v1 = 0; cmd_v2 = 0; cmd_rgb = 0;
    rst_n = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    check(!busy && !done && !fb_we, "R10", "reset outputs", {busy, done, fb_we}, 0);
    check_dirty("R8");

    // R1: wrong opcode ignored
    run_cmd(32'h405, 0, 32'h0007_0000, vpack(1, 1, 0), vpack(5, 3, 0), 1, 0, "R1");
    // R6: mid grey, 24-bit
    run_cmd(32'h411, 0, 32'h0007_0000, vpack(10, 5, 0), vpack(14, 7, 0), 1, 0, "R6");
    // R6: black, then white
    run_cmd(32'h411, 3, 32'h0000_00AA, vpack(2, 2, 3), vpack(6, 2, 3), 1, 0, "R6");
    run_cmd(32'h411, 4, 32'h0042_0000, vpack(30, 8, 4), vpack(33, 9, 4), 1, 0, "R6");
    // R7: indexed low byte
    run_cmd(32'h411, 0, 32'h1234_56A5, vpack(40, 40, 0), vpack(45, 42, 0), 0, 0, "R7");
    // R2: borrow of line width into the y field
    run_cmd(32'h411, 5, 32'h0000_0011, vpack(3, 0, 2), vpack(9, 2, 5), 0, 0, "R2");
    // R3: extra rows from line width, and cap at the last row
    run_cmd(32'h411, 10, 32'h0007_0000, vpack(50, 20, 0) + 10, vpack(52, 21, 0) + 10, 1, 0, "R3");
    run_cmd(32'h411, 9, 32'h0007_0000, vpack(60, 1021, 0) + 9, vpack(62, 1023, 0) + 9, 1, 0, "R3");
    // R4: width cap at 1280 columns
    run_cmd(32'h411, 0, 32'h0000_0001, vpack(100, 30, 0), vpack(1500, 31, 0), 0, 0, "R4");
    // R9: empty in x and in y
    run_cmd(32'h411, 0, 32'h0000_0001, vpack(20, 3, 0), vpack(20, 9, 0), 0, 0, "R9");
    run_cmd(32'h411, 0, 32'h0000_0001, vpack(20, 9, 0), vpack(25, 4, 0), 0, 0, "R9");
    // R1: command offered while busy is dropped
    run_cmd(32'h411, 0, 32'h0007_0000, vpack(70, 60, 0), vpack(76, 63, 0), 1, 1, "R1");
    // R5: random mix
    for (int n = 0; n < 30; n++) begin
      int x, y, x2, y2, lwv;
      logic [31:0] at;
      x   = $urandom % 60;
      x2  = x + ($urandom % 24) - 3;
      if (x2 < 0) x2 = 0;
      y   = $urandom % 40;
      y2  = y + ($urandom % 8) - 1;
      if (y2 < 0) y2 = 0;
      lwv = $urandom % 10;
      at  = $urandom;
      case ($urandom % 3)
        0: at[23:16] = 8'd0;
        1: at[23:16] = 8'd7;
        default: ;
      endcase
      run_cmd(32'h411, 32'(lwv), at, vpack(x, y, $urandom % 8) + 32'(lwv),
              vpack(x2, y2, $urandom % 8) + 32'(lwv), 1'($urandom % 2), 0, "R5");
    end
    finish_up();
  end

endmodule